// File: doc/BRIEF.md
# Compact Branch Resolution Unit

This unit sits in the execute stage of a 32-bit RISC pipeline. It resolves the family of branches and jumps that have no delay slot. Each cycle it receives an instruction word, the PC of that instruction, the two general-register operand values named by the instruction, and a flag that says whether the instruction occupies the delay slot of an earlier delayed branch. On the next rising clock edge it presents four results: whether control transfers, the next PC, a request to write the return address into register 31, and a reserved-instruction exception.

Several instructions share one major opcode. The decoder tells them apart by comparing the two register-number fields, and not the register contents. A `handled` output marks the words that belong to this family. Legacy delayed branches and all other opcodes leave it low, so that other logic can claim them.

Top module: `cbranch_unit`

## Requirements
- R1: While `rst_n` is sampled low at a rising edge, `taken_o`, `link_we_o`, `resv_exc_o` and `handled_o` become 0 and `next_pc_o` becomes 0, whatever the inputs are.
- R2: With major opcode (bits 31:26) 6'h08 or 6'h18, the register-number fields rs (bits 25:21) and rt (bits 20:16) select the operation. If rs >= rt, the instruction branches on add overflow (6'h08) or on no add overflow (6'h18). If rs is 0 and rt is nonzero, it branches with link when rt's value is zero (6'h08) or nonzero (6'h18). In every other case it branches when the operand values are equal (6'h08) or not equal (6'h18).
- R3: The overflow condition holds when the 32-bit two's-complement sum of the rs and rt operand values overflows, in either the positive or the negative direction.
- R4: Opcodes 6'h06 and 6'h07 with a nonzero rt field are link branches in two cases. With rs = 0 they test rt_val <= 0 (6'h06) or rt_val > 0 (6'h07). With rs = rt they test rt_val >= 0 (6'h06) or rt_val < 0 (6'h07). With any other rs they compare rs_val >= rt_val (6'h06) or rs_val < rt_val (6'h07) as unsigned numbers and do not link. With an rt field of 0 the word is not handled.
- R5: Opcodes 6'h16 and 6'h17 use the same rs/rt split as R4, with signed comparisons and no link. An rt field of 0 raises `resv_exc_o` with `handled_o` high.
- R6: Opcode 6'h32 always branches and 6'h3A always branches with link. The target is PC + 4 plus bits 25:0 sign-extended and multiplied by 4.
- R7: Opcodes 6'h36 and 6'h3E with a nonzero rs field branch when rs_val is zero (6'h36) or nonzero (6'h3E). The target is PC + 4 plus bits 20:0 sign-extended and multiplied by 4.
- R8: Opcodes 6'h36 and 6'h3E with an rs field of 0 are jumps to rt_val plus the sign-extended bits 15:0, with no scaling. 6'h3E links and 6'h36 does not.
- R9: The R2, R4 and R5 forms target PC + 4 plus bits 15:0 sign-extended and multiplied by 4. Whenever `taken_o` is low, `next_pc_o` is PC + 4.
- R10: Every link form raises `link_we_o` whether or not it branches, and `link_val_o` then equals PC + 4.
- R11: A handled word presented with `in_dslot_i` high raises `resv_exc_o`, with `taken_o` and `link_we_o` low and `next_pc_o` = PC + 4.
- R12: Any word outside the family leaves `handled_o`, `taken_o`, `link_we_o` and `resv_exc_o` low, even with `in_dslot_i` high, and `next_pc_o` is PC + 4.
- R13: Outputs change only at the rising clock edge that follows the inputs. A change of input between edges is not visible on the outputs until that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| instr_i | input | 32 | Instruction word under resolution |
| pc_i | input | XLEN | Address of that instruction |
| rs_val_i | input | XLEN | Value of the register named by bits 25:21 |
| rt_val_i | input | XLEN | Value of the register named by bits 20:16 |
| in_dslot_i | input | 1 | The instruction occupies a delay slot |
| taken_o | output | 1 | Control transfers to the target |
| next_pc_o | output | XLEN | Address to fetch next |
| link_we_o | output | 1 | Write `link_val_o` into register 31 |
| link_val_o | output | XLEN | Return address (PC + 4) |
| resv_exc_o | output | 1 | Reserved-instruction exception |
| handled_o | output | 1 | Word belongs to the compact family |

## Verification
The hardest case to reach is the overflow form. It occurs only when the rs register number is at least the rt register number, so the stimulus has to pick the register fields and the operand values together. It pairs rs=5/rt=3 with values that overflow upward, values that overflow downward, and values that do not overflow. It then swaps to rs=3/rt=9 with equal values to show that the same opcode becomes an equality test. The rs = rt and rs = 0 splits of opcodes 6'h06/6'h07/6'h16/6'h17 receive the same treatment. The run also checks that a link is still requested when the condition fails. Delay-slot words are paired with an always-taken link form, so that any leak of taken or link would be visible.

// File: rtl/cbu_pkg.sv
// Package: shared types and opcode constants for the compact branch unit.
// Assumes the 6-bit major opcode sits in bits 31:26 of the instruction.
package cbu_pkg;

    localparam logic [5:0] OP_OVF_EQ   = 6'h08;
    localparam logic [5:0] OP_NOVF_NE  = 6'h18;
    localparam logic [5:0] OP_LE_GEU   = 6'h06;
    localparam logic [5:0] OP_GT_LTU   = 6'h07;
    localparam logic [5:0] OP_LE_GE_S  = 6'h16;
    localparam logic [5:0] OP_GT_LT_S  = 6'h17;
    localparam logic [5:0] OP_BR       = 6'h32;
    localparam logic [5:0] OP_BR_LINK  = 6'h3A;
    localparam logic [5:0] OP_ZR_JMP   = 6'h36;
    localparam logic [5:0] OP_NZ_JMPL  = 6'h3E;

    // Condition the evaluator must test
    typedef enum logic [4:0] {
        C_NONE, C_OVF, C_NOVF, C_EQ, C_NE,
        C_RT_EQZ, C_RT_NEZ, C_RT_LEZ, C_RT_GTZ, C_RT_GEZ, C_RT_LTZ,
        C_GEU, C_LTU, C_GES, C_LTS, C_RS_EQZ, C_RS_NEZ, C_ALWAYS
    } cond_e;

    // How the target address is formed
    typedef enum logic [1:0] {
        T_OFF16, T_OFF21, T_OFF26, T_INDIRECT
    } tgt_e;

    typedef struct packed {
        logic  handled;
        logic  resv;
        logic  link;
        cond_e cond;
        tgt_e  tsel;
    } dec_t;

endpackage

// File: rtl/cbu_decode.sv
// Module: cbu_decode
// Classifies the upper half of an instruction word into a compact branch
// form. Instructions that share an opcode are separated by comparing the
// rs and rt register numbers. Purely combinational.
module cbu_decode
    import cbu_pkg::*;
(
    input  logic [15:0] hi_i,     // instruction bits 31:16
    output dec_t        dec_o
);
    logic [5:0] op;
    logic [4:0] rs_n;
    logic [4:0] rt_n;

    assign op   = hi_i[15:10];
    assign rs_n = hi_i[9:5];
    assign rt_n = hi_i[4:0];

    // Opcode and register-number split into condition, link and target kind
    always_comb begin
        dec_o         = '0;
        dec_o.cond    = C_NONE;
        dec_o.tsel    = T_OFF16;
        case (op)
            OP_OVF_EQ, OP_NOVF_NE: begin
                dec_o.handled = 1'b1;
                if (rs_n >= rt_n) begin
                    dec_o.cond = (op == OP_NOVF_NE) ? C_NOVF : C_OVF;
                end else if (rs_n == 5'd0) begin
                    dec_o.cond = (op == OP_NOVF_NE) ? C_RT_NEZ : C_RT_EQZ;
                    dec_o.link = 1'b1;
                end else begin
                    dec_o.cond = (op == OP_NOVF_NE) ? C_NE : C_EQ;
                end
            end
            OP_LE_GEU, OP_GT_LTU: begin
                if (rt_n != 5'd0) begin
                    dec_o.handled = 1'b1;
                    if (rs_n == 5'd0) begin
                        dec_o.cond = (op == OP_GT_LTU) ? C_RT_GTZ : C_RT_LEZ;
                        dec_o.link = 1'b1;
                    end else if (rs_n == rt_n) begin
                        dec_o.cond = (op == OP_GT_LTU) ? C_RT_LTZ : C_RT_GEZ;
                        dec_o.link = 1'b1;
                    end else begin
                        dec_o.cond = (op == OP_GT_LTU) ? C_LTU : C_GEU;
                    end
                end
            end
            OP_LE_GE_S, OP_GT_LT_S: begin
                dec_o.handled = 1'b1;
                if (rt_n == 5'd0) begin
                    dec_o.resv = 1'b1;
                end else if (rs_n == 5'd0) begin
                    dec_o.cond = (op == OP_GT_LT_S) ? C_RT_GTZ : C_RT_LEZ;
                end else if (rs_n == rt_n) begin
                    dec_o.cond = (op == OP_GT_LT_S) ? C_RT_LTZ : C_RT_GEZ;
                end else begin
                    dec_o.cond = (op == OP_GT_LT_S) ? C_LTS : C_GES;
                end
            end
            OP_BR, OP_BR_LINK: begin
                dec_o.handled = 1'b1;
                dec_o.cond    = C_ALWAYS;
                dec_o.tsel    = T_OFF26;
                dec_o.link    = (op == OP_BR_LINK);
            end
            OP_ZR_JMP, OP_NZ_JMPL: begin
                dec_o.handled = 1'b1;
                if (rs_n != 5'd0) begin
                    dec_o.cond = (op == OP_NZ_JMPL) ? C_RS_NEZ : C_RS_EQZ;
                    dec_o.tsel = T_OFF21;
                end else begin
                    dec_o.cond = C_ALWAYS;
                    dec_o.tsel = T_INDIRECT;
                    dec_o.link = (op == OP_NZ_JMPL);
                end
            end
            default: dec_o.handled = 1'b0;
        endcase
    end

endmodule

// File: rtl/cbu_cond.sv
// Module: cbu_cond
// Evaluates the branch condition selected by the decoder on the two
// operand values. Overflow is judged on an XLEN-bit two's-complement add.
module cbu_cond
    import cbu_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  cond_e           cond_i,
    input  logic [XLEN-1:0] rs_val_i,
    input  logic [XLEN-1:0] rt_val_i,
    output logic            true_o
);
    localparam int MSB = XLEN - 1;

    logic [XLEN-1:0] sum;
    logic            ovf;
    logic            rt_zero;
    logic            rt_neg;

    // Signed overflow: result sign differs from both operands' common sign
    always_comb begin
        sum     = rs_val_i + rt_val_i;
        ovf     = ((sum ^ rt_val_i) & ~(rs_val_i ^ rt_val_i)) >> MSB != '0;
        rt_zero = (rt_val_i == '0);
        rt_neg  = rt_val_i[MSB];
    end

    // Condition multiplexer
    always_comb begin
        case (cond_i)
            C_OVF:     true_o = ovf;
            C_NOVF:    true_o = !ovf;
            C_EQ:      true_o = (rs_val_i == rt_val_i);
            C_NE:      true_o = (rs_val_i != rt_val_i);
            C_RT_EQZ:  true_o = rt_zero;
            C_RT_NEZ:  true_o = !rt_zero;
            C_RT_LEZ:  true_o = rt_neg || rt_zero;
            C_RT_GTZ:  true_o = !rt_neg && !rt_zero;
            C_RT_GEZ:  true_o = !rt_neg;
            C_RT_LTZ:  true_o = rt_neg;
            C_GEU:     true_o = (rs_val_i >= rt_val_i);
            C_LTU:     true_o = (rs_val_i < rt_val_i);
            C_GES:     true_o = ($signed(rs_val_i) >= $signed(rt_val_i));
            C_LTS:     true_o = ($signed(rs_val_i) < $signed(rt_val_i));
            C_RS_EQZ:  true_o = (rs_val_i == '0);
            C_RS_NEZ:  true_o = (rs_val_i != '0);
            C_ALWAYS:  true_o = 1'b1;
            default:   true_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/cbu_target.sv
// Module: cbu_target
// Forms the branch or jump destination from the offset field chosen by the
// decoder. PC-relative forms add to PC + 4; the indirect form adds to rt.
module cbu_target
    import cbu_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  tgt_e            tsel_i,
    input  logic [25:0]     field_i,    // instruction bits 25:0
    input  logic [XLEN-1:0] pc_plus4_i,
    input  logic [XLEN-1:0] rt_val_i,
    output logic [XLEN-1:0] target_o
);
    localparam int PAD16 = XLEN - 18;
    localparam int PAD21 = XLEN - 23;
    localparam int PAD26 = XLEN - 28;
    localparam int PADIM = XLEN - 16;

    logic [XLEN-1:0] off16;
    logic [XLEN-1:0] off21;
    logic [XLEN-1:0] off26;
    logic [XLEN-1:0] imm_sx;

    // Sign-extended offsets, word-scaled except for the indirect immediate
    always_comb begin
        off16  = {{PAD16{field_i[15]}}, field_i[15:0], 2'b00};
        off21  = {{PAD21{field_i[20]}}, field_i[20:0], 2'b00};
        off26  = {{PAD26{field_i[25]}}, field_i[25:0], 2'b00};
        imm_sx = {{PADIM{field_i[15]}}, field_i[15:0]};
    end

    // Destination select
    always_comb begin
        case (tsel_i)
            T_OFF21:    target_o = pc_plus4_i + off21;
            T_OFF26:    target_o = pc_plus4_i + off26;
            T_INDIRECT: target_o = rt_val_i + imm_sx;
            default:    target_o = pc_plus4_i + off16;
        endcase
    end

endmodule

// File: rtl/cbranch_unit.sv
// Module: cbranch_unit (top)
// Resolves no-delay-slot branches and jumps and registers the outcome one
// clock after the inputs. Assumes operands are already read from the
// register file; the link write itself is performed elsewhere.
module cbranch_unit
    import cbu_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [31:0]     instr_i,
    input  logic [XLEN-1:0] pc_i,
    input  logic [XLEN-1:0] rs_val_i,
    input  logic [XLEN-1:0] rt_val_i,
    input  logic            in_dslot_i,
    output logic            taken_o,
    output logic [XLEN-1:0] next_pc_o,
    output logic            link_we_o,
    output logic [XLEN-1:0] link_val_o,
    output logic            resv_exc_o,
    output logic            handled_o
);
    localparam logic [XLEN-1:0] STEP = XLEN'(4);

    dec_t            dec;
    logic            cond_true;
    logic [XLEN-1:0] pc_plus4;
    logic [XLEN-1:0] target;
    logic            exc_d;
    logic            taken_d;
    logic            link_d;
    logic [XLEN-1:0] next_pc_d;

    cbu_decode u_dec (
        .hi_i  (instr_i[31:16]),
        .dec_o (dec)
    );

    cbu_cond #(.XLEN(XLEN)) u_cond (
        .cond_i   (dec.cond),
        .rs_val_i (rs_val_i),
        .rt_val_i (rt_val_i),
        .true_o   (cond_true)
    );

    cbu_target #(.XLEN(XLEN)) u_tgt (
        .tsel_i     (dec.tsel),
        .field_i    (instr_i[25:0]),
        .pc_plus4_i (pc_plus4),
        .rt_val_i   (rt_val_i),
        .target_o   (target)
    );

    // Combine decode, condition and slot state into the next outcome
    always_comb begin
        pc_plus4  = pc_i + STEP;
        exc_d     = dec.handled && (dec.resv || in_dslot_i);
        taken_d   = dec.handled && !exc_d && cond_true;
        link_d    = dec.handled && !exc_d && dec.link;
        next_pc_d = taken_d ? target : pc_plus4;
    end

    // Output registers with synchronous active-low reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            taken_o    <= 1'b0;
            next_pc_o  <= '0;
            link_we_o  <= 1'b0;
            link_val_o <= '0;
            resv_exc_o <= 1'b0;
            handled_o  <= 1'b0;
        end else begin
            taken_o    <= taken_d;
            next_pc_o  <= next_pc_d;
            link_we_o  <= link_d;
            link_val_o <= pc_plus4;
            resv_exc_o <= exc_d;
            handled_o  <= dec.handled;
        end
    end

    // R11
    dslot_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_dslot_i && dec.handled) |=> (resv_exc_o && !taken_o && !link_we_o));

    // R12
    unclaimed_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !handled_o |-> (!taken_o && !link_we_o && !resv_exc_o));

    // R9
    fallthru_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !taken_d |=> (next_pc_o == $past(pc_i) + STEP));

    // R10
    link_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        link_d |=> (link_we_o && link_val_o == $past(pc_i) + STEP));

    // R11
    taken_exc_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({taken_o, resv_exc_o}));

    // R5
    rt_zero_resv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((instr_i[31:26] == OP_LE_GE_S || instr_i[31:26] == OP_GT_LT_S)
         && instr_i[20:16] == 5'd0) |=> (resv_exc_o && handled_o));

endmodule

// File: tb/sim_cbranch_unit.sv
// Directed bench for cbranch_unit: one task per scenario, each checking
// the registered outputs one edge after its stimulus.
module sim_cbranch_unit;

    localparam int XLEN = 32;
    localparam logic [31:0] PC  = 32'h0000_1000;
    localparam logic [31:0] PC4 = 32'h0000_1004;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] instr = '0;
    logic [31:0] pc = PC;
    logic [31:0] rs_val = '0;
    logic [31:0] rt_val = '0;
    logic        in_dslot = 1'b0;
    logic        taken;
    logic [31:0] next_pc;
    logic        link_we;
    logic [31:0] link_val;
    logic        resv_exc;
    logic        handled;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    cbranch_unit #(.XLEN(XLEN)) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .instr_i    (instr),
        .pc_i       (pc),
        .rs_val_i   (rs_val),
        .rt_val_i   (rt_val),
        .in_dslot_i (in_dslot),
        .taken_o    (taken),
        .next_pc_o  (next_pc),
        .link_we_o  (link_we),
        .link_val_o (link_val),
        .resv_exc_o (resv_exc),
        .handled_o  (handled)
    );

    function automatic logic [31:0] mk(input logic [5:0] op, input logic [4:0] rs,
                                       input logic [4:0] rt, input logic [15:0] imm);
        return {op, rs, rt, imm};
    endfunction

    task automatic drive(input logic [31:0] w, input logic [31:0] a, input logic [31:0] b,
                         input logic ds);
        @(negedge clk);
        instr = w; pc = PC; rs_val = a; rt_val = b; in_dslot = ds;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic e_tk, input logic [31:0] e_pc,
                       input logic e_lw, input logic e_h, input logic e_x);
        n_vec++;
        if (taken !== e_tk || next_pc !== e_pc || link_we !== e_lw ||
            handled !== e_h || resv_exc !== e_x || (e_lw && link_val !== PC4)) begin
            n_bad++;
            $display("FAIL %s: got tk=%b pc=%h lw=%b lv=%h h=%b x=%b exp tk=%b pc=%h lw=%b lv=%h h=%b x=%b",
                     tag, taken, next_pc, link_we, link_val, handled, resv_exc,
                     e_tk, e_pc, e_lw, PC4, e_h, e_x);
        end
    endtask

    // R1: reset holds outputs cleared even with an always-taken link word
    task automatic t_reset();
        instr = mk(6'h3A, 5'd0, 5'd0, 16'h0010);
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 reset", 1'b0, 32'h0, 1'b0, 1'b0, 1'b0);
        rst_n = 1'b1;
    endtask

    // R2 R3: overflow forms and their register-number split
    task automatic t_overflow();
        drive(mk(6'h08, 5'd5, 5'd3, 16'h0010), 32'h7FFF_FFFF, 32'h1, 1'b0);
        chk("R3 pos ovf taken", 1'b1, PC4 + 32'h40, 1'b0, 1'b1, 1'b0);
        drive(mk(6'h08, 5'd5, 5'd3, 16'h0010), 32'h5, 32'h6, 1'b0);
        chk("R3 no ovf", 1'b0, PC4, 1'b0, 1'b1, 1'b0);
        drive(mk(6'h08, 5'd5, 5'd3, 16'hFFFC), 32'h8000_0000, 32'hFFFF_FFFF, 1'b0);
        chk("R3 neg ovf", 1'b1, PC4 - 32'h10, 1'b0, 1'b1, 1'b0);
        drive(mk(6'h18, 5'd5, 5'd3, 16'h0010), 32'h1, 32'h2, 1'b0);
        chk("R2 no-ovf form", 1'b1, PC4 + 32'h40, 1'b0, 1'b1, 1'b0);
        drive(mk(6'h08, 5'd3, 5'd9, 16'h0010), 32'h55, 32'h55, 1'b0);
        chk("R2 equal form", 1'b1, PC4 + 32'h40, 1'b0, 1'b1, 1'b0);
        drive(mk(6'h18, 5'd3, 5'd9, 16'h0010), 32'h55, 32'h55, 1'b0);
        chk("R2 not-equal form", 1'b0, PC4, 1'b0, 1'b1, 1'b0);
    endtask

    // R2 R10: zero test with link, link even when not taken
    task automatic t_zero_link();
        drive(mk(6'h08, 5'd0, 5'd4, 16'h0008), 32'h0, 32'h0, 1'b0);
        chk("R2 rt==0 link taken", 1'b1, PC4 + 32'h20, 1'b1, 1'b1, 1'b0);
        drive(mk(6'h08, 5'd0, 5'd4, 16'h0008), 32'h0, 32'h5, 1'b0);
        chk("R10 link when not taken", 1'b0, PC4, 1'b1, 1'b1, 1'b0);
        drive(mk(6'h18, 5'd0, 5'd4, 16'h0008), 32'h0, 32'h5, 1'b0);
        chk("R2 rt!=0 link", 1'b1, PC4 + 32'h20, 1'b1, 1'b1, 1'b0);
    endtask

    // R4: opcodes 6'h06 and 6'h07
    task automatic t_link_cmp();
        drive(mk(6'h06, 5'd0, 5'd4, 16'h0004), 32'h0, 32'h0, 1'b0);
        chk("R4 rt<=0 link", 1'b1, PC4 + 32'h10, 1'b1, 1'b1, 1'b0);
        drive(mk(6'h06, 5'd0, 5'd4, 16'h0004), 32'h0, 32'h1, 1'b0);
        chk("R4 rt<=0 false", 1'b0, PC4, 1'b1, 1'b1, 1'b0);
        drive(mk(6'h07, 5'd7, 5'd7, 16'h0004), 32'h8000_0000, 32'h8000_0000, 1'b0);
        chk("R4 rt<0 link", 1'b1, PC4 + 32'h10, 1'b1, 1'b1, 1'b0);
        drive(mk(6'h06, 5'd2, 5'd3, 16'h0004), 32'hFFFF_FFFF, 32'h1, 1'b0);
        chk("R4 unsigned ge", 1'b1, PC4 + 32'h10, 1'b0, 1'b1, 1'b0);
        drive(mk(6'h07, 5'd2, 5'd3, 16'h0004), 32'hFFFF_FFFF, 32'h1, 1'b0);
        chk("R4 unsigned lt", 1'b0, PC4, 1'b0, 1'b1, 1'b0);
        drive(mk(6'h06, 5'd2, 5'd0, 16'h0004), 32'h0, 32'h0, 1'b0);
        chk("R4 rt field 0 unhandled", 1'b0, PC4, 1'b0, 1'b0, 1'b0);
    endtask

    // R5: signed forms and reserved rt field
    task automatic t_signed();
        drive(mk(6'h16, 5'd2, 5'd3, 16'h0004), 32'hFFFF_FFFF, 32'h1, 1'b0);
        chk("R5 signed ge false", 1'b0, PC4, 1'b0, 1'b1, 1'b0);
        drive(mk(6'h17, 5'd2, 5'd3, 16'h0004), 32'hFFFF_FFFF, 32'h1, 1'b0);
        chk("R5 signed lt", 1'b1, PC4 + 32'h10, 1'b0, 1'b1, 1'b0);
        drive(mk(6'h17, 5'd0, 5'd4, 16'h0004), 32'h0, 32'h5, 1'b0);
        chk("R5 rt>0 no link", 1'b1, PC4 + 32'h10, 1'b0, 1'b1, 1'b0);
        drive(mk(6'h16, 5'd6, 5'd6, 16'h0004), 32'h0, 32'h0, 1'b0);
        chk("R5 rt>=0", 1'b1, PC4 + 32'h10, 1'b0, 1'b1, 1'b0);
        drive(mk(6'h16, 5'd6, 5'd0, 16'h0004), 32'h0, 32'h0, 1'b0);
        chk("R5 rt field 0 reserved", 1'b0, PC4, 1'b0, 1'b1, 1'b1);
    endtask

    // R6: 26-bit offset branches
    task automatic t_long();
        drive({6'h32, 26'h3FF_FFFF}, 32'h0, 32'h0, 1'b0);
        chk("R6 branch -1 word", 1'b1, PC, 1'b0, 1'b1, 1'b0);
        drive({6'h3A, 26'h000_0100}, 32'h0, 32'h0, 1'b0);
        chk("R6 branch link", 1'b1, PC4 + 32'h400, 1'b1, 1'b1, 1'b0);
    endtask

    // R7 R8: rs zero tests and indirect jumps
    task automatic t_rs_forms();
        drive({6'h36, 5'd4, 21'h10_0000}, 32'h0, 32'h0, 1'b0);
        chk("R7 rs==0 far back", 1'b1, PC4 + 32'hFFC0_0000, 1'b0, 1'b1, 1'b0);
        drive({6'h3E, 5'd4, 21'h00_0002}, 32'h0, 32'h0, 1'b0);
        chk("R7 rs!=0 false", 1'b0, PC4, 1'b0, 1'b1, 1'b0);
        drive(mk(6'h36, 5'd0, 5'd8, 16'hFFF0), 32'h0, 32'h2000, 1'b0);
        chk("R8 indirect", 1'b1, 32'h0000_1FF0, 1'b0, 1'b1, 1'b0);
        drive(mk(6'h3E, 5'd0, 5'd8, 16'h0003), 32'h0, 32'h2000, 1'b0);
        chk("R8 indirect link", 1'b1, 32'h0000_2003, 1'b1, 1'b1, 1'b0);
    endtask

    // R11 R12: delay slot and foreign opcodes
    task automatic t_slot_other();
        drive({6'h3A, 26'h000_0100}, 32'h0, 32'h0, 1'b1);
        chk("R11 dslot blocked", 1'b0, PC4, 1'b0, 1'b1, 1'b1);
        drive(mk(6'h00, 5'd1, 5'd2, 16'h0000), 32'h0, 32'h0, 1'b1);
        chk("R12 foreign in dslot", 1'b0, PC4, 1'b0, 1'b0, 1'b0);
        drive(mk(6'h04, 5'd1, 5'd1, 16'h0010), 32'h0, 32'h0, 1'b0);
        chk("R12 foreign opcode", 1'b0, PC4, 1'b0, 1'b0, 1'b0);
    endtask

    // R13: outputs hold until the next rising edge
    task automatic t_latency();
        drive({6'h32, 26'h000_0004}, 32'h0, 32'h0, 1'b0);
        @(negedge clk);
        instr = mk(6'h00, 5'd0, 5'd0, 16'h0);
        #2;
        chk("R13 hold before edge", 1'b1, PC4 + 32'h10, 1'b0, 1'b1, 1'b0);
        @(posedge clk);
        @(negedge clk);
        chk("R13 update after edge", 1'b0, PC4, 1'b0, 1'b0, 1'b0);
    endtask

    initial begin
        t_reset();
        t_overflow();
        t_zero_link();
        t_link_cmp();
        t_signed();
        t_long();
        t_rs_forms();
        t_slot_other();
        t_latency();
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: got hung run exp completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule